// File: doc/BRIEF.md
# ADC Conversion Engine Controller

This block sits between a register bus and a shared analog-to-digital converter. Software starts a conversion by setting an engine's bit in the enable register. The block passes the request to the converter through a start pulse and an engine select. When the converter reports completion, the block stores the 12-bit result in that engine's data register. It then clears the enable bit and records the event in a status register. Software learns that a conversion has finished either by polling the enable bit until it reads back as zero or by taking the interrupt.

There are two converting engines: an auxiliary input engine and a battery engine. Only one conversion is in flight at a time. If both engines are requested, the lower-numbered engine is served first. Two configuration fields are passed straight to the converter: a selector that picks one of two auxiliary inputs, and a flag that selects a low reference range for the battery. A power-down bit in the enable register holds back every new start. Interrupt status bits are cleared by writing ones to them. The single interrupt line is the OR of the status bits that the mask register leaves unmasked.

Top module: `adc_engine_ctrl`

## Requirements
- R1: After reset, enable (offset 0x00) reads 0, config (0x04) reads 0, mask (0x08) reads 0xFF, status (0x0C) reads 0, both data registers (0x1C battery, 0x20 auxiliary) read 0, and `irq` is low.
- R2: Writing 1 to enable bit 0 (auxiliary) or bit 1 (battery) requests a conversion, which produces a one-cycle `conv_start` pulse with `conv_sel` = 0 for auxiliary and 1 for battery. Writing 0 to either of these bits has no effect. Enable bit 2 (touch) is stored and read back as written, and never produces a start.
- R3: When `conv_done` arrives for the engine in flight, the block does three things in the same cycle. It stores `conv_data` in that engine's data register, which reads back in bits [11:0] with bits [31:12] zero. It clears the engine's enable bit. It sets the engine's status bit: bit 0 for auxiliary, bit 1 for battery.
- R4: At most one conversion is in flight. When both request bits are set, the auxiliary engine (bit 0) starts first and the battery engine starts after it completes.
- R5: While enable bit 7 (power-down) is 1, no new conversion starts and pending request bits stay set. Once bit 7 is cleared, the pending requests are served.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a completion sets a bit in the same cycle as a write clears it, the bit ends up set.
- R7: A mask bit of 1 hides the matching status bit. `irq` is high exactly when some status bit is 1 and its mask bit is 0.
- R8: Config bits [1:0] choose the auxiliary input. The value 2 drives `conv_aux_input` high (second input), and the values 0, 1 and 3 drive it low (first input).
- R9: Config bit 4 drives `conv_low_ref`, which selects the low battery reference range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational while reg_valid and !reg_write |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_sel | output | 1 | Engine in flight: 0 auxiliary, 1 battery |
| conv_aux_input | output | 1 | Auxiliary input choice: 0 first, 1 second |
| conv_low_ref | output | 1 | Low battery reference range |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 12 | Converter result, valid with conv_done |
| irq | output | 1 | OR of unmasked status bits |

## Verification
The hardest situation to reach from the ports is a status-clear write that lands in the same clock edge as a completion setting that same bit. The stimulus watches for `conv_done` just after a falling edge and issues the clear write within the same half cycle. A second awkward case is a request that is left pending under power-down and then released by a write of zero, which must not cancel it. The bench covers this by writing 0x81, idling, and then writing 0x00. It also checks that both engines are started in ascending order when they are requested in the same write.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
    // Converting engines and their indices (enable/status bit positions)
    localparam int NENG    = 2;
    localparam int ENG_AUX = 0;
    localparam int ENG_BAT = 1;
    localparam int SEL_W   = (NENG > 1) ? $clog2(NENG) : 1;

    // Register byte offsets
    localparam logic [7:0] OFS_ENABLE  = 8'h00;
    localparam logic [7:0] OFS_CONFIG  = 8'h04;
    localparam logic [7:0] OFS_MASK    = 8'h08;
    localparam logic [7:0] OFS_STATUS  = 8'h0C;
    localparam logic [7:0] OFS_BATDATA = 8'h1C;
    localparam logic [7:0] OFS_AUXDATA = 8'h20;

    // Bit positions
    localparam int BIT_TOUCH  = 2;
    localparam int BIT_PWRDN  = 7;
    localparam int CFG_LOWREF = 4;
    localparam int FLAG_W     = 8;
endpackage

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
    import adc_ctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [FLAG_W-1:0] wdata,
    input  logic [NENG-1:0]   cmpl,
    output logic [FLAG_W-1:0] enable_o,
    output logic [1:0]        aux_mode_o,
    output logic              low_ref_o,
    output logic [FLAG_W-1:0] mask_o,
    output logic [FLAG_W-1:0] status_o
);
    typedef struct packed {
        logic [FLAG_W-1:0] en;
        logic [1:0]        amode;
        logic              lowref;
        logic [FLAG_W-1:0] mask;
        logic [FLAG_W-1:0] stat;
    } regs_t;

    regs_t q, d;
    logic [FLAG_W-1:0] hw_set;
    logic [FLAG_W-1:0] sw_clr;

    always_comb begin
        d      = q;
        hw_set = '0;
        hw_set[NENG-1:0] = cmpl;
        sw_clr = '0;
        // Engine request bits drop on completion; a write can only set them
        d.en[NENG-1:0] = q.en[NENG-1:0] & ~cmpl;
        if (wr) begin
            if (addr == ADDR_W'(OFS_ENABLE)) begin
                d.en[NENG-1:0] = d.en[NENG-1:0] | wdata[NENG-1:0];
                d.en[BIT_TOUCH] = wdata[BIT_TOUCH];
                d.en[BIT_PWRDN] = wdata[BIT_PWRDN];
            end
            if (addr == ADDR_W'(OFS_CONFIG)) begin
                d.amode  = wdata[1:0];
                d.lowref = wdata[CFG_LOWREF];
            end
            if (addr == ADDR_W'(OFS_MASK)) begin
                d.mask = wdata;
            end
            if (addr == ADDR_W'(OFS_STATUS)) begin
                sw_clr = wdata;
            end
        end
        // Hardware set takes priority over a simultaneous clear
        d.stat = (q.stat & ~sw_clr) | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.en     <= '0;
            q.amode  <= '0;
            q.lowref <= 1'b0;
            q.mask   <= '1;
            q.stat   <= '0;
        end else begin
            q <= d;
        end
    end

    assign enable_o   = q.en;
    assign aux_mode_o = q.amode;
    assign low_ref_o  = q.lowref;
    assign mask_o     = q.mask;
    assign status_o   = q.stat;

    for (genvar i = 0; i < NENG; i++) begin : g_eng_chk
        // R3: completion drops the request unless a write re-arms it
        a_r3_enable_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            (cmpl[i] && !(wr && addr == ADDR_W'(OFS_ENABLE) && wdata[i])) |=> !q.en[i]);
        // R6: completion wins over clear
        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            cmpl[i] |=> q.stat[i]);
    end

    for (genvar j = 0; j < FLAG_W; j++) begin : g_stat_chk
        // R6: write-one-to-clear
        a_r6_status_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && addr == ADDR_W'(OFS_STATUS) && wdata[j] && !hw_set[j]) |=> !q.stat[j]);
    end
endmodule

// File: rtl/adc_ctl_sched.sv
module adc_ctl_sched
    import adc_ctl_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NENG-1:0]              req,
    input  logic                         pwrdn,
    input  logic                         conv_done,
    input  logic [DATA_W-1:0]            conv_data,
    output logic                         conv_start,
    output logic [SEL_W-1:0]             conv_sel,
    output logic [NENG-1:0]              cmpl,
    output logic [NENG-1:0][DATA_W-1:0]  eng_data
);
    typedef struct packed {
        logic                        busy;
        logic                        start;
        logic [SEL_W-1:0]            sel;
        logic [NENG-1:0][DATA_W-1:0] data;
    } sched_t;

    sched_t q, d;
    logic [SEL_W-1:0] pick;
    logic [NENG-1:0]  cmpl_c;

    // Lowest-numbered pending engine wins
    always_comb begin
        pick = '0;
        for (int i = NENG - 1; i >= 0; i--) begin
            if (req[i]) pick = SEL_W'(i);
        end
    end

    always_comb begin
        d       = q;
        d.start = 1'b0;
        cmpl_c  = '0;
        if (q.busy) begin
            if (conv_done) begin
                d.busy         = 1'b0;
                d.data[q.sel]  = conv_data;
                cmpl_c[q.sel]  = 1'b1;
            end
        end else if (!pwrdn && (|req)) begin
            d.busy  = 1'b1;
            d.start = 1'b1;
            d.sel   = pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign conv_start = q.start;
    assign conv_sel   = q.sel;
    assign cmpl       = cmpl_c;
    assign eng_data   = q.data;

    // R2: start is a single-cycle pulse
    a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R4: no lower-numbered request was pending when a higher engine started
    a_r4_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (($past(req) & ~({NENG{1'b1}} << conv_sel)) == '0));
    // R4: completion reports exactly one engine
    a_r4_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmpl) |-> $onehot(cmpl));
    // R5: no start is issued out of power-down
    a_r5_no_start_pwrdn: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !$past(pwrdn));
endmodule

// File: rtl/adc_engine_ctrl.sv
module adc_engine_ctrl
    import adc_ctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int REG_W  = 32,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              conv_start,
    output logic [SEL_W-1:0]  conv_sel,
    output logic              conv_aux_input,
    output logic              conv_low_ref,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              irq
);
    logic                        wr;
    logic [FLAG_W-1:0]           enable_q;
    logic [1:0]                  aux_mode_q;
    logic                        low_ref_q;
    logic [FLAG_W-1:0]           mask_q;
    logic [FLAG_W-1:0]           status_q;
    logic [NENG-1:0]             cmpl;
    logic [NENG-1:0][DATA_W-1:0] eng_data;
    logic                        unused_wdata;

    assign wr           = reg_valid & reg_write;
    assign unused_wdata = ^reg_wdata[REG_W-1:FLAG_W];

    adc_ctl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata[FLAG_W-1:0]),
        .cmpl       (cmpl),
        .enable_o   (enable_q),
        .aux_mode_o (aux_mode_q),
        .low_ref_o  (low_ref_q),
        .mask_o     (mask_q),
        .status_o   (status_q)
    );

    adc_ctl_sched #(.DATA_W(DATA_W)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (enable_q[NENG-1:0]),
        .pwrdn      (enable_q[BIT_PWRDN]),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .conv_start (conv_start),
        .conv_sel   (conv_sel),
        .cmpl       (cmpl),
        .eng_data   (eng_data)
    );

    assign conv_aux_input = (aux_mode_q == 2'd2);
    assign conv_low_ref   = low_ref_q;
    assign irq            = |(status_q & ~mask_q);

    always_comb begin
        reg_rdata = '0;
        if (reg_valid && !reg_write) begin
            case (reg_addr)
                ADDR_W'(OFS_ENABLE):  reg_rdata[FLAG_W-1:0] = enable_q;
                ADDR_W'(OFS_CONFIG): begin
                    reg_rdata[1:0]        = aux_mode_q;
                    reg_rdata[CFG_LOWREF] = low_ref_q;
                end
                ADDR_W'(OFS_MASK):    reg_rdata[FLAG_W-1:0] = mask_q;
                ADDR_W'(OFS_STATUS):  reg_rdata[FLAG_W-1:0] = status_q;
                ADDR_W'(OFS_BATDATA): reg_rdata[DATA_W-1:0] = eng_data[ENG_BAT];
                ADDR_W'(OFS_AUXDATA): reg_rdata[DATA_W-1:0] = eng_data[ENG_AUX];
                default:              reg_rdata = '0;
            endcase
        end
    end

    // R7: a fully masked status never raises the line
    a_r7_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq);
endmodule

// File: tb/tb_adc_engine_ctrl.sv
`timescale 1ns/1ps
module tb_adc_engine_ctrl;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        conv_start;
    logic [0:0]  conv_sel;
    logic        conv_aux_input;
    logic        conv_low_ref;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    adc_engine_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .conv_start(conv_start), .conv_sel(conv_sel), .conv_aux_input(conv_aux_input),
        .conv_low_ref(conv_low_ref), .conv_done(conv_done), .conv_data(conv_data),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Converter model: result encodes engine, aux input, range and a sequence number
    int          lat = 0;
    int          seq = 0;
    logic [11:0] pend = '0;
    int          starts[$];
    always @(negedge clk) begin
        if (!rst_n) begin
            lat = 0;
            conv_done = 1'b0;
        end else begin
            conv_done = 1'b0;
            if (lat == 1) begin
                conv_done = 1'b1;
                conv_data = pend;
            end
            if (lat > 0) lat--;
            if (conv_start) begin
                lat = LAT;
                seq++;
                pend = {conv_sel[0], conv_aux_input, conv_low_ref, 9'(seq)};
                starts.push_back(int'(conv_sel));
            end
        end
    end

    // Behavioural reference model
    logic [7:0]  m_en, m_mask, m_stat;
    logic [1:0]  m_amode;
    logic        m_lowref, m_busy, m_start;
    int          m_sel;
    logic [11:0] m_data [2];
    always @(posedge clk) begin : model
        logic [7:0] en_n, st_n;
        logic       fin;
        if (!rst_n) begin
            m_en <= '0; m_mask <= 8'hFF; m_stat <= '0; m_amode <= '0; m_lowref <= 1'b0;
            m_busy <= 1'b0; m_start <= 1'b0; m_sel <= 0;
            m_data[0] <= '0; m_data[1] <= '0;
        end else begin
            en_n = m_en; st_n = m_stat;
            fin  = m_busy && conv_done;
            if (fin) en_n[m_sel] = 1'b0;
            if (reg_valid && reg_write) begin
                case (reg_addr)
                    8'h00: begin
                        en_n[1:0] = en_n[1:0] | reg_wdata[1:0];
                        en_n[2]   = reg_wdata[2];
                        en_n[7]   = reg_wdata[7];
                    end
                    8'h04: begin m_amode <= reg_wdata[1:0]; m_lowref <= reg_wdata[4]; end
                    8'h08: m_mask <= reg_wdata[7:0];
                    8'h0C: st_n = st_n & ~reg_wdata[7:0];
                    default: ;
                endcase
            end
            if (fin) begin
                st_n[m_sel] = 1'b1;
                m_data[m_sel] <= conv_data;
            end
            m_start <= 1'b0;
            if (fin) m_busy <= 1'b0;
            else if (!m_busy && !m_en[7] && (m_en[1:0] != 2'b00)) begin
                m_busy <= 1'b1; m_start <= 1'b1; m_sel <= m_en[0] ? 0 : 1;
            end
            m_en <= en_n; m_stat <= st_n;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            chk("R2 conv_start", 32'(conv_start), 32'(m_start));
            if (m_start) chk("R4 conv_sel", 32'(conv_sel), 32'(m_sel));
            chk("R7 irq", 32'(irq), 32'(|(m_stat & ~m_mask)));
            chk("R8 aux input", 32'(conv_aux_input), 32'(m_amode == 2'd2));
            chk("R9 low ref", 32'(conv_low_ref), 32'(m_lowref));
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); #1;
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); #1;
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); #1;
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #0.5 v = reg_rdata;
        reg_valid = 1'b0;
    endtask

    task automatic poll_idle(input string req);
        logic [31:0] v;
        for (int k = 0; k < 100; k++) begin
            bus_rd(8'h00, v);
            if (v[1:0] == 2'b00) break;
        end
        chk(req, 32'(v[1:0]), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        bus_rd(8'h00, v); chk("R1 enable", v, 32'h0);
        bus_rd(8'h04, v); chk("R1 config", v, 32'h0);
        bus_rd(8'h08, v); chk("R1 mask", v, 32'hFF);
        bus_rd(8'h0C, v); chk("R1 status", v, 32'h0);
        bus_rd(8'h1C, v); chk("R1 bat data", v, 32'h0);
        bus_rd(8'h20, v); chk("R1 aux data", v, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2/R3: single auxiliary conversion
        bus_wr(8'h00, 32'h01);
        poll_idle("R3 aux enable self-clears");
        bus_rd(8'h0C, v); chk("R3 aux status", v, 32'h01);
        bus_rd(8'h20, v); chk("R3 aux data", v, {20'h0, m_data[0]});
        chk("R3 aux data engine bit", 32'(v[11]), 32'h0);
        chk("R7 masked irq low", 32'(irq), 32'h0);

        // R7/R6
        bus_wr(8'h08, 32'hFE);
        chk("R7 unmasked irq high", 32'(irq), 32'h1);
        bus_wr(8'h0C, 32'h00);
        bus_rd(8'h0C, v); chk("R6 zero write keeps", v, 32'h01);
        bus_wr(8'h0C, 32'h01);
        bus_rd(8'h0C, v); chk("R6 w1c", v, 32'h0);
        chk("R7 irq after clear", 32'(irq), 32'h0);

        // R8: auxiliary input selection
        bus_wr(8'h04, 32'h02);
        bus_rd(8'h04, v); chk("R8 config readback", v, 32'h02);
        bus_wr(8'h00, 32'h01);
        poll_idle("R8 conversion done");
        bus_rd(8'h20, v); chk("R8 second input used", 32'(v[10]), 32'h1);
        bus_wr(8'h04, 32'h01);
        chk("R8 value 1 first input", 32'(conv_aux_input), 32'h0);
        bus_wr(8'h04, 32'h03);
        chk("R8 value 3 first input", 32'(conv_aux_input), 32'h0);

        // R9: battery in low-reference mode
        bus_wr(8'h04, 32'h10);
        chk("R9 low ref out", 32'(conv_low_ref), 32'h1);
        bus_wr(8'h0C, 32'hFF);
        bus_wr(8'h00, 32'h02);
        poll_idle("R3 battery enable self-clears");
        bus_rd(8'h1C, v); chk("R3 bat data", v, {20'h0, m_data[1]});
        chk("R9 bat data low ref", 32'(v[11:9]), 32'h5);
        bus_rd(8'h0C, v); chk("R3 bat status", v, 32'h02);

        // R4: both engines at once
        bus_wr(8'h0C, 32'hFF);
        starts.delete();
        bus_wr(8'h00, 32'h03);
        poll_idle("R4 both done");
        chk("R4 start count", 32'(starts.size()), 32'd2);
        if (starts.size() == 2) begin
            chk("R4 first aux", 32'(starts[0]), 32'd0);
            chk("R4 second bat", 32'(starts[1]), 32'd1);
        end
        bus_rd(8'h0C, v); chk("R4 both status", v, 32'h03);

        // R5: power-down holds requests; writing 0 does not cancel
        starts.delete();
        bus_wr(8'h00, 32'h81);
        repeat (20) @(posedge clk);
        bus_rd(8'h00, v); chk("R5 pending kept", v, 32'h81);
        chk("R5 no start", 32'(starts.size()), 32'd0);
        bus_wr(8'h00, 32'h00);
        poll_idle("R5 released request served");
        chk("R5 one start after release", 32'(starts.size()), 32'd1);

        // R2: touch bit stored, no start
        starts.delete();
        bus_wr(8'h00, 32'h04);
        repeat (5) @(posedge clk);
        bus_rd(8'h00, v); chk("R2 touch bit readback", v, 32'h04);
        chk("R2 touch no start", 32'(starts.size()), 32'd0);
        bus_wr(8'h00, 32'h00);

        // R6: clear coinciding with completion, set wins
        bus_wr(8'h0C, 32'hFF);
        bus_wr(8'h00, 32'h01);
        for (int k = 0; k < 50; k++) begin
            @(negedge clk); #1;
            if (conv_done) break;
        end
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 8'h0C; reg_wdata = 32'h01;
        @(negedge clk); #1;
        reg_valid = 1'b0; reg_write = 1'b0;
        bus_rd(8'h0C, v); chk("R6 set wins over clear", v, 32'h01);

        repeat (4) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule